// File: doc/BRIEF.md
# Boundary Scan Chain with Signature and Pattern Modes

This block is the boundary register that wraps a bus transceiver's data pins for board-level test. A separate test-access controller decodes its state machine and instruction register. It passes this block one-hot state strobes for capture, shift, update and idle, a chain-select line, and three mode lines. The chain observes the data-input pads and the driven output pads. It shifts serially from `scan_in` to `scan_out` and holds a separate update register for driving the outputs in test mode.

Two in-place modes reuse the chain as a linear feedback register while the controller sits in idle. Signature mode folds the data-input values into the register on every test clock. Pattern mode drives the output pads from the register as a free-running pseudo-random source. Outside the test modes, the output pads carry the core's functional values untouched. Sampling and shifting never disturb the functional values. Capturing the driven output pads back into the chain allows the cells to test themselves.

Top module: `bsc_psa_prpg_top`

## Requirements
- R1: A synchronous active-high `rst` clears the chain, the update register, `scan_out` and `scan_out_en` to zero.
- R2: On a rising `tclk` with `st_shift` and `sel_chain` high, the chain moves one place toward bit 0 and `scan_in` enters bit L-1, where L = N_IN+N_OUT. On each falling edge `scan_out` takes chain bit 0, and `scan_out_en` takes `st_shift & sel_chain`.
- R3: On a rising edge with `st_capture` and `sel_chain` high, chain bits [N_IN-1:0] load `pad_in` and bits [L-1:N_IN] load the current `pad_out`. Capture takes priority over shift.
- R4: The update register loads chain bits [L-1:N_IN] only on a rising edge with `st_update` and `sel_chain` high, and holds its value otherwise.
- R5: With `mode_drive` and `mode_gen` both low, `pad_out` equals `core_out` in every cycle, whatever the chain does.
- R6: With `mode_drive` high and `mode_gen` low, `pad_out` equals the update register.
- R7: On a rising edge with `st_idle`, `sel_chain` and `mode_sig` high, `mode_gen` low, and neither capture nor shift asserted, the chain becomes step(c) XOR {N_OUT zeros, `pad_in`}. Here step(c) = {c[0]^c[7], c[L-1:1]}, which for L=18 is the primitive polynomial x^18+x^11+1.
- R8: On a rising edge with `st_idle`, `sel_chain` and `mode_gen` high and neither capture nor shift asserted, a nonzero chain becomes step(c). While `mode_gen` is high, `pad_out` equals chain bits [L-1:N_IN]. Pattern mode takes priority over signature and drive modes.
- R9: A pattern step taken from an all-zero chain loads the seed value 1 instead, so pattern mode never locks at zero.
- R10: With `sel_chain` low, the capture, shift, update and idle strobes leave the chain and the update register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_in | input | 1 | Serial data into the chain |
| st_capture | input | 1 | Controller is in the capture state |
| st_shift | input | 1 | Controller is in the shift state |
| st_update | input | 1 | Controller is in the update state |
| st_idle | input | 1 | Controller is in the idle state |
| sel_chain | input | 1 | Current instruction selects the boundary chain |
| mode_drive | input | 1 | Output pads driven from the update register |
| mode_sig | input | 1 | Signature compression in idle |
| mode_gen | input | 1 | Pseudo-random pattern generation in idle |
| pad_in | input | N_IN | Data-input pad values |
| core_out | input | N_OUT | Functional output values from the core |
| pad_out | output | N_OUT | Values driven onto the output pads |
| scan_out | output | 1 | Serial data out, changes on falling edge |
| scan_out_en | output | 1 | Output enable for the serial pad, high only in shift |

## Verification
Chain and update-register results appear on the rising edge that samples the strobe. `pad_out` follows combinationally from those registers, so it is compared one time unit after each rising edge. `scan_out` and `scan_out_en` lag by one further half cycle and are compared just after each falling edge, against the chain value the reference model held after the previous rising edge. Stimulus changes only just after falling edges, so every edge sees settled inputs. Signature and pattern contents are also shifted out afterwards, which exposes every bit serially.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD    = 3'd0,
    OP_CAPTURE = 3'd1,
    OP_SHIFT   = 3'd2,
    OP_SIG     = 3'd3,
    OP_GEN     = 3'd4
  } chain_op_e;
endpackage

// File: rtl/bsc_op_decode.sv
module bsc_op_decode
  import bsc_pkg::*;
(
  input  logic      sel_chain,
  input  logic      st_capture,
  input  logic      st_shift,
  input  logic      st_idle,
  input  logic      mode_sig,
  input  logic      mode_gen,
  output chain_op_e op
);
  always_comb begin
    op = OP_HOLD;
    if (sel_chain) begin
      if (st_capture)              op = OP_CAPTURE;
      else if (st_shift)           op = OP_SHIFT;
      else if (st_idle && mode_gen) op = OP_GEN;
      else if (st_idle && mode_sig) op = OP_SIG;
    end
  end
endmodule

// File: rtl/bsc_chain.sv
module bsc_chain
  import bsc_pkg::*;
#(
  parameter int          N_IN  = 9,
  parameter int          N_OUT = 9,
  parameter logic [63:0] TAPS  = 64'h81,
  parameter logic [63:0] SEED  = 64'h1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  chain_op_e               op,
  input  logic                    si,
  input  logic [N_IN-1:0]         pad_in,
  input  logic [N_OUT-1:0]        pad_obs,
  output logic [N_IN+N_OUT-1:0]   chain_q
);
  localparam int L = N_IN + N_OUT;
  localparam logic [L-1:0] TAP_MASK  = TAPS[L-1:0];
  localparam logic [L-1:0] SEED_VAL  = SEED[L-1:0];

  function automatic logic [L-1:0] lfsr_step(input logic [L-1:0] s);
    return {^(s & TAP_MASK), s[L-1:1]};
  endfunction

  logic [L-1:0] sig_mix;
  logic [L-1:0] nxt;

  // signature injection: each input cell XORs its pad into its own stage
  genvar g;
  generate
    for (g = 0; g < L; g++) begin : g_mix
      if (g < N_IN) begin : g_in
        assign sig_mix[g] = pad_in[g];
      end else begin : g_out
        assign sig_mix[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    nxt = chain_q;
    unique case (op)
      OP_CAPTURE: nxt = {pad_obs, pad_in};
      OP_SHIFT:   nxt = {si, chain_q[L-1:1]};
      OP_SIG:     nxt = lfsr_step(chain_q) ^ sig_mix;
      OP_GEN:     nxt = (chain_q == '0) ? SEED_VAL : lfsr_step(chain_q);
      default:    nxt = chain_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= nxt;
  end
endmodule

// File: rtl/bsc_update_reg.sv
module bsc_update_reg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bsc_serial_out.sv
module bsc_serial_out (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic bit_in,
  output logic so,
  output logic so_en
);
  always_ff @(negedge clk) begin
    if (rst) begin
      so    <= 1'b0;
      so_en <= 1'b0;
    end else begin
      so    <= bit_in;
      so_en <= shift_en;
    end
  end
endmodule

// File: rtl/bsc_psa_prpg_top.sv
module bsc_psa_prpg_top
  import bsc_pkg::*;
#(
  parameter int          N_IN  = 9,
  parameter int          N_OUT = 9,
  parameter logic [63:0] TAPS  = 64'h81,
  parameter logic [63:0] SEED  = 64'h1
) (
  input  logic             tclk,
  input  logic             rst,
  input  logic             scan_in,
  input  logic             st_capture,
  input  logic             st_shift,
  input  logic             st_update,
  input  logic             st_idle,
  input  logic             sel_chain,
  input  logic             mode_drive,
  input  logic             mode_sig,
  input  logic             mode_gen,
  input  logic [N_IN-1:0]  pad_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pad_out,
  output logic             scan_out,
  output logic             scan_out_en
);
  localparam int L = N_IN + N_OUT;

  chain_op_e        op;
  logic [L-1:0]     chain_q;
  logic [N_OUT-1:0] upd_q;

  bsc_op_decode u_dec (
    .sel_chain (sel_chain),
    .st_capture(st_capture),
    .st_shift  (st_shift),
    .st_idle   (st_idle),
    .mode_sig  (mode_sig),
    .mode_gen  (mode_gen),
    .op        (op)
  );

  bsc_chain #(.N_IN(N_IN), .N_OUT(N_OUT), .TAPS(TAPS), .SEED(SEED)) u_chain (
    .clk    (tclk),
    .rst    (rst),
    .op     (op),
    .si     (scan_in),
    .pad_in (pad_in),
    .pad_obs(pad_out),
    .chain_q(chain_q)
  );

  bsc_update_reg #(.W(N_OUT)) u_upd (
    .clk (tclk),
    .rst (rst),
    .load(st_update && sel_chain),
    .d   (chain_q[L-1:N_IN]),
    .q   (upd_q)
  );

  bsc_serial_out u_so (
    .clk     (tclk),
    .rst     (rst),
    .shift_en(st_shift && sel_chain),
    .bit_in  (chain_q[0]),
    .so      (scan_out),
    .so_en   (scan_out_en)
  );

  always_comb begin
    if (mode_gen)        pad_out = chain_q[L-1:N_IN];
    else if (mode_drive) pad_out = upd_q;
    else                 pad_out = core_out;
  end
endmodule

// File: rtl/bsc_checks.sv
module bsc_checks #(
  parameter int N_IN  = 9,
  parameter int N_OUT = 9
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scan_in,
  input logic                  st_capture,
  input logic                  st_shift,
  input logic                  st_update,
  input logic                  st_idle,
  input logic                  sel_chain,
  input logic                  mode_drive,
  input logic                  mode_gen,
  input logic [N_IN-1:0]       pad_in,
  input logic [N_OUT-1:0]      core_out,
  input logic [N_OUT-1:0]      pad_out,
  input logic [N_IN+N_OUT-1:0] chain_q,
  input logic [N_OUT-1:0]      upd_q
);
  localparam int L = N_IN + N_OUT;

  a_r2_shift_entry: assert property (@(posedge clk) disable iff (rst)
    (st_shift && sel_chain && !st_capture) |=> chain_q[L-1] == $past(scan_in));

  a_r3_capture_inputs: assert property (@(posedge clk) disable iff (rst)
    (st_capture && sel_chain) |=> chain_q[N_IN-1:0] == $past(pad_in));

  a_r4_update_hold: assert property (@(posedge clk) disable iff (rst)
    !(st_update && sel_chain) |=> $stable(upd_q));

  a_r5_passthru: assert property (@(posedge clk) disable iff (rst)
    (!mode_drive && !mode_gen) |-> pad_out == core_out);

  a_r6_drive_update: assert property (@(posedge clk) disable iff (rst)
    (mode_drive && !mode_gen) |-> pad_out == upd_q);

  a_r9_gen_nonzero: assert property (@(posedge clk) disable iff (rst)
    (sel_chain && st_idle && mode_gen && !st_capture && !st_shift) |=> chain_q != '0);

  a_r10_deselect_hold: assert property (@(posedge clk) disable iff (rst)
    !sel_chain |=> $stable(chain_q));
endmodule

bind bsc_psa_prpg_top bsc_checks #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk       (tclk),
  .rst       (rst),
  .scan_in   (scan_in),
  .st_capture(st_capture),
  .st_shift  (st_shift),
  .st_update (st_update),
  .st_idle   (st_idle),
  .sel_chain (sel_chain),
  .mode_drive(mode_drive),
  .mode_gen  (mode_gen),
  .pad_in    (pad_in),
  .core_out  (core_out),
  .pad_out   (pad_out),
  .chain_q   (chain_q),
  .upd_q     (upd_q)
);

// File: tb/sim_bsc_psa_prpg_top.sv
module sim_bsc_psa_prpg_top;
  localparam int TCLK_PERIOD = 10;

  logic       tclk = 1'b0;
  logic       rst = 1'b1;
  logic       scan_in = 1'b0;
  logic       st_capture = 1'b0, st_shift = 1'b0, st_update = 1'b0, st_idle = 1'b0;
  logic       sel_chain = 1'b0, mode_drive = 1'b0, mode_sig = 1'b0, mode_gen = 1'b0;
  logic [8:0] pad_in = '0;
  logic [8:0] core_out = '0;
  logic [8:0] pad_out;
  logic       scan_out, scan_out_en;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference state
  logic [17:0] m_chain = '0;
  logic [8:0]  m_upd = '0;
  logic        m_so = 1'b0, m_en = 1'b0;

  always #(TCLK_PERIOD/2) tclk = ~tclk;

  bsc_psa_prpg_top u0 (
    .tclk(tclk), .rst(rst), .scan_in(scan_in),
    .st_capture(st_capture), .st_shift(st_shift), .st_update(st_update), .st_idle(st_idle),
    .sel_chain(sel_chain), .mode_drive(mode_drive), .mode_sig(mode_sig), .mode_gen(mode_gen),
    .pad_in(pad_in), .core_out(core_out), .pad_out(pad_out),
    .scan_out(scan_out), .scan_out_en(scan_out_en)
  );

  function automatic logic [17:0] poly_step(input logic [17:0] s);
    logic fb;
    fb = s[0] ^ s[7];
    return {fb, s[17:1]};
  endfunction

  function automatic logic [8:0] model_pads();
    if (mode_gen)        return m_chain[17:9];
    else if (mode_drive) return m_upd;
    else                 return core_out;
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // one test-clock cycle; inputs were set just after the previous falling edge
  task automatic cyc(input string tag);
    logic [17:0] nc;
    logic [8:0]  nu;
    nc = m_chain;
    nu = m_upd;
    if (rst) begin
      nc = '0; nu = '0;
    end else if (sel_chain) begin
      if (st_capture)                nc = {model_pads(), pad_in};
      else if (st_shift)             nc = {scan_in, m_chain[17:1]};
      else if (st_idle && mode_gen)  nc = (m_chain == 0) ? 18'd1 : poly_step(m_chain);
      else if (st_idle && mode_sig)  nc = poly_step(m_chain) ^ {9'd0, pad_in};
      if (st_update) nu = m_chain[17:9];
    end
    @(posedge tclk);
    m_chain = nc;
    m_upd = nu;
    #1;
    check({tag, " pad_out"}, {9'd0, pad_out}, {9'd0, model_pads()});
    @(negedge tclk);
    if (rst) begin m_so = 0; m_en = 0; end
    else begin m_so = m_chain[0]; m_en = st_shift && sel_chain; end
    #1;
    check({tag, " scan_out"}, {17'd0, scan_out}, {17'd0, m_so});
    check({tag, " scan_out_en"}, {17'd0, scan_out_en}, {17'd0, m_en});
  endtask

  task automatic clr_strobes();
    st_capture = 0; st_shift = 0; st_update = 0; st_idle = 0;
  endtask

  initial begin
    #(TCLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge tclk); #1;
    core_out = 9'h15A;
    for (int i = 0; i < 3; i++) cyc("R1");
    rst = 0;

    // R5: functional values pass through
    for (int i = 0; i < 6; i++) begin
      core_out = 9'($urandom); pad_in = 9'($urandom);
      cyc("R5");
    end

    // R3: capture pads, then R2: shift out with random serial data
    sel_chain = 1; pad_in = 9'h0C3; core_out = 9'h1A5;
    st_capture = 1; cyc("R3");
    clr_strobes(); st_shift = 1;
    for (int i = 0; i < 20; i++) begin
      scan_in = 1'($urandom);
      cyc("R2");
    end

    // R4/R6: update then drive
    clr_strobes(); st_update = 1; cyc("R4");
    clr_strobes(); mode_drive = 1;
    st_shift = 1;
    for (int i = 0; i < 10; i++) begin
      scan_in = 1'($urandom); core_out = 9'($urandom);
      cyc("R6");
    end
    clr_strobes(); st_update = 1; cyc("R4");
    clr_strobes(); cyc("R6");
    // R3: capture of driven pads (self-test loop)
    st_capture = 1; pad_in = 9'h111; cyc("R3");
    clr_strobes(); mode_drive = 0;

    // R10: deselected strobes have no effect
    sel_chain = 0;
    st_capture = 1; pad_in = 9'h1FF; cyc("R10");
    clr_strobes(); st_shift = 1; scan_in = 1; cyc("R10");
    clr_strobes(); st_update = 1; cyc("R10");
    clr_strobes(); st_idle = 1; mode_sig = 1; cyc("R10");
    clr_strobes(); mode_sig = 0; mode_drive = 1; cyc("R10");
    mode_drive = 0;
    sel_chain = 1; st_shift = 1;
    for (int i = 0; i < 18; i++) begin scan_in = 1'($urandom); cyc("R10"); end

    // R7: signature compression in idle
    clr_strobes(); st_idle = 1; mode_sig = 1;
    for (int i = 0; i < 25; i++) begin pad_in = 9'($urandom); cyc("R7"); end
    clr_strobes(); mode_sig = 0; st_shift = 1; scan_in = 0;
    for (int i = 0; i < 18; i++) cyc("R7");

    // R9/R8: chain now zero, pattern mode seeds then runs
    clr_strobes(); mode_gen = 1; mode_drive = 1; mode_sig = 1; st_idle = 1;
    cyc("R9");
    for (int i = 0; i < 40; i++) begin pad_in = 9'($urandom); core_out = 9'($urandom); cyc("R8"); end
    clr_strobes(); st_shift = 1;
    for (int i = 0; i < 18; i++) cyc("R8");
    clr_strobes(); mode_gen = 0; mode_drive = 0; mode_sig = 0;
    cyc("R5");

    // R1: reset mid-run
    rst = 1; st_shift = 1; cyc("R1"); cyc("R1");
    rst = 0; clr_strobes(); mode_drive = 1; cyc("R1");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule